// File: doc/BRIEF.md
# CPU Exception Priority Sequencer

This block sits next to a small CPU core. It gathers the exception requests that the core and its neighbours raise: a restart, an undefined opcode, single-step tracing, a bad memory access, an external interrupt and a software trap. It then decides which one the core takes next. Some sources are served in any cycle of normal execution. Others wait for an instruction boundary, which is either an instruction retiring or the end of the handling of an earlier exception. When several sources compete at the same moment, a fixed ranking picks one of them. The others stay latched and are served at later opportunities.

The external reset pin passes through a two-stage synchronizer. While the pin is low the core is held in reset and every latched request is dropped. The reset exception is granted once, after the synchronized pin has risen. A watchdog overflow pulse starts the same reset exception without holding the core. Each grant is a single-cycle strobe with a one-hot vector and a 3-bit code. After a grant the sequencer treats the core as busy handling an exception until the core reports the end of that handling.

Top module: `exc_prio_seq`

## Requirements
- R1: While `res_n` is low, `hold_rst` is 1, `grant_vld` is 0 and every latched request is discarded. Requests that arrive during the two synchronizer cycles after `res_n` rises are also discarded.
- R2: `hold_rst` falls two clock edges after `res_n` rises. The reset exception (code 1, `grant_oh` bit 0) is granted on the following edge. A `wdt_ovf` pulse while `hold_rst` is 0 grants code 1 on the next edge. Both forms of reset clear all latched requests.
- R3: The ranking is reset (code 1) > illegal (2) > trace (3) > address error (4) > interrupt (5) > trap (6). Code 0 means no grant. `grant_oh` bit k-1 marks code k. At most one grant is issued per cycle, and each grant lasts one cycle.
- R4: An `ill_req` pulse is granted (code 2) on the next edge in any cycle of program execution. It needs no instruction boundary.
- R5: A trace exception (code 3) is raised at a boundary only when `trace_bit` is 1 and `int_mode` equals 2. It is never raised at a boundary where `ret_kind` is 2 (return from exception).
- R6: An `addr_err` pulse is latched and granted (code 4) only at a boundary.
- R7: An interrupt (code 5) is granted only at a boundary. It is not granted at a boundary where `ret_kind` is 1 (control-register write). It is also not granted at the `hnd_done` that ends reset handling. In both cases the request stays latched.
- R8: A `trap_req` is granted (code 6) in any execution cycle. Execution means not held in reset and either not busy or in the `hnd_done` cycle.
- R9: After any grant the core counts as busy until `hnd_done`. While busy, only reset can be granted and `ret_vld` is ignored. While not busy, `hnd_done` is ignored.
- R10: A request that loses arbitration stays latched and is granted at a later opportunity, in ranking order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | External reset pin, active low, asynchronous assertion |
| wdt_ovf | input | 1 | Watchdog overflow pulse |
| ill_req | input | 1 | Undefined opcode executed |
| addr_err | input | 1 | Address error raised by the current instruction |
| irq_req | input | 1 | Interrupt request pulse from the interrupt controller |
| trap_req | input | 1 | Trap instruction executed |
| trace_bit | input | 1 | Trace enable flag of the core |
| int_mode | input | MODE_W | Interrupt control mode |
| ret_vld | input | 1 | An instruction retired this cycle |
| ret_kind | input | 2 | Kind of retired instruction: 0/3 ordinary, 1 control-register write, 2 return from exception |
| hnd_done | input | 1 | Exception handling finished this cycle |
| hold_rst | output | 1 | Core held in reset state |
| grant_vld | output | 1 | Single-cycle grant strobe |
| grant_oh | output | 6 | One-hot grant, bit k-1 for code k |
| grant_code | output | 3 | Granted exception code, 0 when none |

## Verification
A request pulse, a boundary strobe and a watchdog pulse all give their grant on the first clock edge after the cycle that carries them. The bench drives inputs on the falling edge and compares outputs on the next falling edge, against a model stepped once per cycle. A rising reset pin takes longer. `hold_rst` falls after the second edge and the reset grant appears after the third, and both the model and the directed checks count exactly those edges. Requests that wait for a boundary are checked both in cycles that have no boundary, where no grant is expected, and in the boundary cycle itself.

// File: rtl/exc_prio_seq.sv
module exc_prio_seq #(
  parameter int MODE_W      = 2,
  parameter int TRACE_MODE  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              res_n,
  input  logic              wdt_ovf,
  input  logic              ill_req,
  input  logic              addr_err,
  input  logic              irq_req,
  input  logic              trap_req,
  input  logic              trace_bit,
  input  logic [MODE_W-1:0] int_mode,
  input  logic              ret_vld,
  input  logic [1:0]        ret_kind,
  input  logic              hnd_done,
  output logic              hold_rst,
  output logic              grant_vld,
  output logic [5:0]        grant_oh,
  output logic [2:0]        grant_code
);

  localparam int NSRC = 6;
  localparam logic [1:0] K_CTRL = 2'd1;
  localparam logic [1:0] K_RTE  = 2'd2;

  logic [SYNC_STAGES:0] sync_q;
  logic p_ill, p_tr, p_ae, p_irq, p_trap;
  logic busy, rst_hnd;
  logic rise, rst_ev, exec_ok, bnd_ret, bnd_hnd, bnd, trace_now, irq_ok;
  logic [NSRC-1:0] cand, pick;
  logic [2:0] code_n;

  always_ff @(posedge clk or negedge res_n)
    if (!res_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], 1'b1};

  assign hold_rst  = !sync_q[SYNC_STAGES-1];
  assign rise      = sync_q[SYNC_STAGES-1] & !sync_q[SYNC_STAGES];
  assign rst_ev    = rise | (wdt_ovf & !hold_rst);
  assign exec_ok   = !hold_rst & (!busy | hnd_done);
  assign bnd_ret   = ret_vld & !busy & !hold_rst;
  assign bnd_hnd   = hnd_done & busy & !hold_rst;
  assign bnd       = bnd_ret | bnd_hnd;
  assign trace_now = bnd & trace_bit & (int_mode == MODE_W'(TRACE_MODE))
                   & !(bnd_ret & (ret_kind == K_RTE));
  assign irq_ok    = !(bnd_ret & (ret_kind == K_CTRL)) & !(bnd_hnd & rst_hnd);

  assign cand[0] = rst_ev;
  assign cand[1] = exec_ok & (p_ill | ill_req);
  assign cand[2] = bnd & (p_tr | trace_now);
  assign cand[3] = bnd & (p_ae | addr_err);
  assign cand[4] = bnd & irq_ok & (p_irq | irq_req);
  assign cand[5] = exec_ok & (p_trap | trap_req);

  always_comb begin
    logic found;
    found  = 1'b0;
    pick   = '0;
    code_n = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && !found) begin
        found   = 1'b1;
        pick[i] = 1'b1;
        code_n  = 3'(i + 1);
      end
    end
  end

  always_ff @(posedge clk or negedge res_n) begin
    if (!res_n) begin
      {p_ill, p_tr, p_ae, p_irq, p_trap} <= '0;
    end else if (hold_rst || rst_ev) begin
      {p_ill, p_tr, p_ae, p_irq, p_trap} <= '0;
    end else begin
      p_ill  <= (p_ill  | ill_req)   & !pick[1];
      p_tr   <= (p_tr   | trace_now) & !pick[2];
      p_ae   <= (p_ae   | addr_err)  & !pick[3];
      p_irq  <= (p_irq  | irq_req)   & !pick[4];
      p_trap <= (p_trap | trap_req)  & !pick[5];
    end
  end

  always_ff @(posedge clk or negedge res_n) begin
    if (!res_n) begin
      busy    <= 1'b0;
      rst_hnd <= 1'b0;
    end else if (hold_rst) begin
      busy    <= 1'b0;
      rst_hnd <= 1'b0;
    end else if (|pick) begin
      busy    <= 1'b1;
      rst_hnd <= pick[0];
    end else if (bnd_hnd) begin
      busy    <= 1'b0;
      rst_hnd <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge res_n) begin
    if (!res_n) begin
      grant_vld  <= 1'b0;
      grant_oh   <= '0;
      grant_code <= '0;
    end else begin
      grant_vld  <= |pick;
      grant_oh   <= pick;
      grant_code <= code_n;
    end
  end

endmodule

// File: rtl/exc_prio_seq_chk.sv
module exc_prio_seq_chk (
  input logic       clk,
  input logic       res_n,
  input logic       wdt_ovf,
  input logic       ill_req,
  input logic       trap_req,
  input logic       ret_vld,
  input logic [1:0] ret_kind,
  input logic       hnd_done,
  input logic       busy,
  input logic       hold_rst,
  input logic       grant_vld,
  input logic [2:0] grant_code
);

  AST_HOLD_IN_RESET: assert property (@(posedge clk)
    !res_n |-> (hold_rst && !grant_vld)); // R1

  AST_RESET_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!res_n)
    $fell(hold_rst) |=> (grant_vld && grant_code == 3'd1)); // R2

  AST_WDT_RESET: assert property (@(posedge clk) disable iff (!res_n)
    (wdt_ovf && !hold_rst) |=> (grant_vld && grant_code == 3'd1)); // R2

  AST_ILL_NO_BOUNDARY: assert property (@(posedge clk) disable iff (!res_n)
    (ill_req && !busy && !hold_rst && !wdt_ovf && !$fell(hold_rst))
      |=> (grant_code == 3'd2)); // R4

  AST_IRQ_CTRL_BLOCK: assert property (@(posedge clk) disable iff (!res_n)
    (ret_vld && ret_kind == 2'd1 && !busy) |=> (grant_code != 3'd5)); // R7

  AST_BUSY_ONLY_RESET: assert property (@(posedge clk) disable iff (!res_n)
    (grant_vld && !hnd_done && !wdt_ovf) |=> !grant_vld); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!res_n)
    (!busy && !hold_rst && !$fell(hold_rst) && !ret_vld && !ill_req
     && !trap_req && !wdt_ovf) |=> !grant_vld); // R9

endmodule

bind exc_prio_seq exc_prio_seq_chk u_chk (
  .clk(clk), .res_n(res_n), .wdt_ovf(wdt_ovf), .ill_req(ill_req),
  .trap_req(trap_req), .ret_vld(ret_vld), .ret_kind(ret_kind),
  .hnd_done(hnd_done), .busy(busy), .hold_rst(hold_rst),
  .grant_vld(grant_vld), .grant_code(grant_code)
);

// File: tb/tb_exc_prio_seq.sv
module tb_exc_prio_seq;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic res_n, wdt_ovf, ill_req, addr_err, irq_req, trap_req, trace_bit;
  logic [1:0] int_mode, ret_kind;
  logic ret_vld, hnd_done;
  logic hold_rst, grant_vld;
  logic [5:0] grant_oh;
  logic [2:0] grant_code;

  int errs = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  exc_prio_seq dut (
    .clk(clk), .res_n(res_n), .wdt_ovf(wdt_ovf), .ill_req(ill_req),
    .addr_err(addr_err), .irq_req(irq_req), .trap_req(trap_req),
    .trace_bit(trace_bit), .int_mode(int_mode), .ret_vld(ret_vld),
    .ret_kind(ret_kind), .hnd_done(hnd_done), .hold_rst(hold_rst),
    .grant_vld(grant_vld), .grant_oh(grant_oh), .grant_code(grant_code)
  );

  logic [2:0] ms = '0;
  logic m_ill = 0, m_tr = 0, m_ae = 0, m_irq = 0, m_trap = 0, m_busy = 0, m_rh = 0;
  logic e_hold = 1'b1, e_vld = 1'b0;
  logic [5:0] e_oh = '0;
  logic [2:0] e_code = '0;

  task automatic model_step();
    logic hold, rise, rev, ex, bret, bhnd, bnd, tnow, iok, found;
    logic [5:0] cand, pick;
    if (!res_n) begin
      ms = '0;
      {m_ill, m_tr, m_ae, m_irq, m_trap, m_busy, m_rh} = '0;
      e_vld = 0; e_oh = '0; e_code = '0; e_hold = 1;
      return;
    end
    hold = !ms[1];
    rise = ms[1] && !ms[2];
    rev  = rise || (wdt_ovf && !hold);
    ex   = !hold && (!m_busy || hnd_done);
    bret = ret_vld && !m_busy && !hold;
    bhnd = hnd_done && m_busy && !hold;
    bnd  = bret || bhnd;
    tnow = bnd && trace_bit && int_mode == 2'd2 && !(bret && ret_kind == 2'd2);
    iok  = !(bret && ret_kind == 2'd1) && !(bhnd && m_rh);
    cand = {ex && (m_trap || trap_req), bnd && iok && (m_irq || irq_req),
            bnd && (m_ae || addr_err), bnd && (m_tr || tnow),
            ex && (m_ill || ill_req), rev};
    pick = '0; found = 0; e_code = '0;
    for (int i = 0; i < 6; i++)
      if (cand[i] && !found) begin found = 1; pick[i] = 1; e_code = 3'(i + 1); end
    e_vld = found; e_oh = pick;
    if (hold || rev) {m_ill, m_tr, m_ae, m_irq, m_trap} = '0;
    else begin
      m_ill  = (m_ill  || ill_req)  && !pick[1];
      m_tr   = (m_tr   || tnow)     && !pick[2];
      m_ae   = (m_ae   || addr_err) && !pick[3];
      m_irq  = (m_irq  || irq_req)  && !pick[4];
      m_trap = (m_trap || trap_req) && !pick[5];
    end
    if (hold) begin m_busy = 0; m_rh = 0; end
    else if (found) begin m_busy = 1; m_rh = pick[0]; end
    else if (bhnd) begin m_busy = 0; m_rh = 0; end
    ms = {ms[1:0], 1'b1};
    e_hold = !ms[1];
  endtask

  function automatic string auto_tag(logic [2:0] c);
    case (c)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R3";
    endcase
  endfunction

  task automatic cyc(input string tag, input int hand);
    string t;
    model_step();
    @(negedge clk);
    checks++;
    if (hold_rst !== e_hold || grant_vld !== e_vld || grant_oh !== e_oh || grant_code !== e_code) begin
      errs++;
      t = tag;
      if (t == "") t = (hold_rst !== e_hold) ? "R1" : auto_tag(e_code != 0 ? e_code : grant_code);
      $display("FAIL %s: hold=%0b vld=%0b oh=%b code=%0d, expected hold=%0b vld=%0b oh=%b code=%0d",
               t, hold_rst, grant_vld, grant_oh, grant_code, e_hold, e_vld, e_oh, e_code);
    end
    if (hand >= 0) begin
      checks++;
      if (int'(grant_code) != hand) begin
        errs++;
        $display("FAIL %s: code=%0d expected %0d", tag, grant_code, hand);
      end
    end
  endtask

  task automatic clr();
    {wdt_ovf, ill_req, addr_err, irq_req, trap_req, ret_vld, hnd_done} = '0;
    ret_kind = 2'd0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: run still active, expected finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    res_n = 0; clr(); trace_bit = 0; int_mode = 2'd2;
    @(negedge clk);
    // R1: held while pin low
    cyc("R1", 0); cyc("R1", 0);
    checks++;
    if (hold_rst !== 1'b1) begin errs++; $display("FAIL R1: hold=%0b expected 1", hold_rst); end
    // R2: release, hold falls after two edges, grant on third
    res_n = 1; ill_req = 1;
    cyc("R1", 0); ill_req = 0;
    checks++;
    if (hold_rst !== 1'b1) begin errs++; $display("FAIL R2: hold=%0b expected 1", hold_rst); end
    cyc("R2", 0);
    checks++;
    if (hold_rst !== 1'b0) begin errs++; $display("FAIL R2: hold=%0b expected 0", hold_rst); end
    cyc("R2", 1);
    // R7: interrupt blocked at end of reset handling, served at next boundary
    hnd_done = 1; irq_req = 1; cyc("R7", 0); clr();
    ret_vld = 1; cyc("R7", 5); clr();
    hnd_done = 1; cyc("R9", 0); clr();
    // R7: control-register write blocks interrupt
    irq_req = 1; ret_vld = 1; ret_kind = 2'd1; cyc("R7", 0); clr();
    ret_vld = 1; cyc("R7", 5); clr();
    hnd_done = 1; cyc("R9", 0); clr();
    // R3 / R10: all sources at once, served in ranking order
    ill_req = 1; addr_err = 1; irq_req = 1; trap_req = 1; trace_bit = 1; ret_vld = 1;
    cyc("R3", 2); clr(); trace_bit = 0;
    hnd_done = 1; cyc("R10", 3);
    hnd_done = 1; cyc("R10", 4);
    hnd_done = 1; cyc("R10", 5);
    hnd_done = 1; cyc("R10", 6);
    hnd_done = 1; cyc("R10", 0); clr();
    // R5: trace mode and return-from-exception
    trace_bit = 1; int_mode = 2'd0; ret_vld = 1; cyc("R5", 0);
    int_mode = 2'd2; ret_kind = 2'd2; cyc("R5", 0);
    ret_kind = 2'd0; cyc("R5", 3); clr(); trace_bit = 0;
    hnd_done = 1; cyc("R9", 0); clr();
    // R4 / R8 / R9: illegal without boundary, trap held while busy
    ill_req = 1; cyc("R4", 2); clr();
    trap_req = 1; cyc("R9", 0); clr();
    ret_vld = 1; cyc("R9", 0); clr();
    hnd_done = 1; cyc("R8", 6);
    hnd_done = 1; cyc("R9", 0); clr();
    trap_req = 1; cyc("R8", 6); clr();
    hnd_done = 1; cyc("R8", 0); clr();
    // R6: address error waits for a boundary
    addr_err = 1; cyc("R6", 0); clr();
    cyc("R6", 0);
    ret_vld = 1; cyc("R6", 4); clr();
    hnd_done = 1; cyc("R6", 0); clr();
    // R2: watchdog reset clears pending requests
    addr_err = 1; cyc("R6", 0); clr();
    wdt_ovf = 1; cyc("R2", 1); clr();
    hnd_done = 1; cyc("R2", 0); clr();
    ret_vld = 1; cyc("R2", 0); clr();
    // random phase
    for (int n = 0; n < 4000; n++) begin
      ill_req   = ($urandom % 100) < 4;
      addr_err  = ($urandom % 100) < 6;
      irq_req   = ($urandom % 100) < 8;
      trap_req  = ($urandom % 100) < 4;
      ret_vld   = ($urandom % 100) < 40;
      ret_kind  = 2'($urandom % 4);
      hnd_done  = ($urandom % 100) < 30;
      trace_bit = ($urandom % 100) < 25;
      int_mode  = (($urandom % 2) == 0) ? 2'd2 : 2'($urandom % 4);
      wdt_ovf   = ($urandom % 200) == 0;
      if (!res_n) res_n = ($urandom % 3) == 0;
      else        res_n = ($urandom % 300) != 0;
      cyc("", -1);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule